// File: doc/BRIEF.md
# Folded Symmetric Transposed FIR Sub-Filter

This block is a single-rate FIR filter for a coefficient set whose taps mirror each other about the centre, h(k) = h(M-1-k). Only the unique half of the coefficients is held, as a packed parameter. Each incoming sample is multiplied once by every unique coefficient. Every product then drives the two taps of the transposed adder-register chain that share that coefficient. An M-tap filter therefore needs ceil(M/2) multipliers instead of M.

The block is meant to sit inside a parallel fast FIR filter as one of its sub-filters. Sum and difference polyphase sets of a symmetric prototype are still symmetric, so each of them can be built with this folded form. A parameter selects anti-symmetric operation, h(M-1-k) = -h(k), in which the mirrored tap receives the negated product.

The chain advances only on cycles with a valid sample. The result is registered, so a valid sample produces a valid output one clock later.

Top module: `sym_fold_fir`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, out_valid is 0 and out_data is 0. Reset clears every partial sum, so the first output after reset equals h(0) times the first sample.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid high, and 0 otherwise.
- R3: Each valid output equals the full convolution sum over k of h(k)*x(n-k), where x(n) is the sample just accepted and earlier samples count only if they were accepted since reset. Here h(k) = c(min(k, M-1-k)), and c(j) is the two's-complement field at bits [j*CW +: CW] of COEF. All data are two's complement.
- R4: When M is odd, the centre coefficient c((M-1)/2) drives exactly one tap.
- R5: With ANTI = 1, h(k) = -c(M-1-k) for every k > M-1-k. With odd M the centre coefficient must then be zero, which is checked at elaboration.
- R6: A cycle without in_valid leaves the partial sums and out_data unchanged. The next valid output is computed as if that cycle had not occurred.
- R7: out_data is W+CW+ceil(log2 M) bits wide and holds the exact result for extreme inputs (-2^(W-1) and 2^(W-1)-1) without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; advances the chain |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | W+CW+ceil(log2 M) | Signed filtered result |

## Verification
Two things happen in the same cycle whenever samples arrive back to back. A product is added into a freshly accepted tap, and the same product also feeds its mirrored tap, whose partial sum is leaving the chain as the output. Back-to-back sweeps of every input value provoke this case, along with extreme-value runs, gaps in the valid strobe and a reset in the middle of a stream. Every result is judged bit-exact against a convolution that the bench computes from the fully unfolded coefficient list. The bench does this for an odd-length symmetric instance and for an even-length anti-symmetric instance.

// File: rtl/fold_fir_pkg.sv
package fold_fir_pkg;
   // accumulator width: full product plus growth for M terms
   function automatic int fold_acc_w(input int w, input int cw, input int m);
      return w + cw + $clog2(m);
   endfunction

   // number of distinct coefficients (multipliers)
   function automatic int fold_half(input int m);
      return (m + 1) / 2;
   endfunction

   // which unique coefficient serves tap k
   function automatic int fold_src(input int k, input int m);
      return (k < m - 1 - k) ? k : m - 1 - k;
   endfunction
endpackage

// File: rtl/fold_fir_mults.sv
module fold_fir_mults
   import fold_fir_pkg::*;
#(
   parameter int W    = 8,
   parameter int CW   = 8,
   parameter int HALF = 4,
   parameter logic [HALF*CW-1:0] COEF = '0,
   localparam int PW  = W + CW
)(
   input  logic signed [W-1:0]  x,
   output logic signed [PW-1:0] prod [HALF]
);
   for (genvar j = 0; j < HALF; j++) begin : g_mul
      localparam logic signed [CW-1:0] CJ = COEF[j*CW +: CW];
      logic signed [CW-1:0] cj;
      assign cj      = CJ;
      assign prod[j] = x * cj;
   end
endmodule

// File: rtl/fold_fir_chain.sv
module fold_fir_chain
   import fold_fir_pkg::*;
#(
   parameter int M    = 7,
   parameter int PW   = 16,
   parameter int AW   = 19,
   parameter bit ANTI = 1'b0,
   localparam int HALF = fold_half(M)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [PW-1:0] prod [HALF],
   output logic signed [AW-1:0] sum_out,
   output logic signed [AW-1:0] head
);
   logic signed [AW-1:0] tap_p [M];
   logic signed [AW-1:0] part  [1:M-1];

   // route each product to its one or two taps, sign-extended
   for (genvar k = 0; k < M; k++) begin : g_route
      localparam int J   = fold_src(k, M);
      localparam bit NEG = ANTI && (k > M - 1 - k);
      logic signed [AW-1:0] ext;
      assign ext = {{(AW-PW){prod[J][PW-1]}}, prod[J]};
      if (NEG) begin : g_neg
         assign tap_p[k] = -ext;
      end else begin : g_pos
         assign tap_p[k] = ext;
      end
   end

   // transposed adder-register chain
   for (genvar k = 1; k < M; k++) begin : g_stage
      if (k == M - 1) begin : g_last
         always_ff @(posedge clk) begin
            if (!rst_n)  part[k] <= '0;
            else if (en) part[k] <= tap_p[k];
         end
      end else begin : g_mid
         always_ff @(posedge clk) begin
            if (!rst_n)  part[k] <= '0;
            else if (en) part[k] <= tap_p[k] + part[k+1];
         end
      end
   end

   assign head    = part[1];
   assign sum_out = tap_p[0] + part[1];
endmodule

// File: rtl/sym_fold_fir.sv
module sym_fold_fir
   import fold_fir_pkg::*;
#(
   parameter int W    = 8,
   parameter int CW   = 8,
   parameter int M    = 7,
   parameter bit ANTI = 1'b0,
   parameter logic [fold_half(M)*CW-1:0] COEF = {8'h80, 8'h12, 8'hFD, 8'h05},
   localparam int HALF = fold_half(M),
   localparam int PW   = W + CW,
   localparam int AW   = fold_acc_w(W, CW, M)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [W-1:0]  in_data,
   output logic                 out_valid,
   output logic signed [AW-1:0] out_data
);
   // elaboration-time parameter checks
   if (W < 2)  begin : g_bad_w  $error("W must be at least 2");  end
   if (CW < 2) begin : g_bad_cw $error("CW must be at least 2"); end
   if (M < 2)  begin : g_bad_m  $error("M must be at least 2");  end
   if (ANTI && (M % 2 == 1) && (COEF[(HALF-1)*CW +: CW] != '0)) begin : g_bad_ctr
      $error("anti-symmetric odd length needs a zero centre coefficient");
   end

   logic signed [PW-1:0] prod [HALF];
   logic signed [AW-1:0] chain_sum;
   logic signed [AW-1:0] chain_head;

   fold_fir_mults #(.W(W), .CW(CW), .HALF(HALF), .COEF(COEF)) u_mul (
      .x    (in_data),
      .prod (prod)
   );

   fold_fir_chain #(.M(M), .PW(PW), .AW(AW), .ANTI(ANTI)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (in_valid),
      .prod    (prod),
      .sum_out (chain_sum),
      .head    (chain_head)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= chain_sum;
      end
   end
endmodule

// File: rtl/fold_fir_chk.sv
module fold_fir_chk #(
   parameter int W  = 8,
   parameter int AW = 19
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic signed [W-1:0]  in_data,
   input logic                 out_valid,
   input logic signed [AW-1:0] out_data,
   input logic signed [AW-1:0] head
);
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && out_data == '0));

   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !$rose(rst_n)) |=> $stable(out_data));

   p_zero_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data == '0) |=> (out_data == $past(head)));
endmodule

bind sym_fold_fir fold_fir_chk #(.W(W), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data),
   .head      (chain_head)
);

// File: tb/sim_sym_fold_fir.sv
`timescale 1ns/1ps
module sim_sym_fold_fir;
   localparam int W  = 8;
   localparam int AW = 19;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [W-1:0] in_data = '0;
   logic out_valid0, out_valid1;
   logic signed [AW-1:0] out_data0, out_data1;

   always #10 clk = ~clk;

   // odd length, symmetric: c = 5, -3, 18, -128
   sym_fold_fir #(.W(8), .CW(8), .M(7), .ANTI(1'b0),
                  .COEF({8'h80, 8'h12, 8'hFD, 8'h05})) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid0), .out_data(out_data0));

   // even length, anti-symmetric: c = 127, -128, 9
   sym_fold_fir #(.W(8), .CW(8), .M(6), .ANTI(1'b1),
                  .COEF({8'h09, 8'h80, 8'h7F})) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid1), .out_data(out_data1));

   // fully unfolded coefficient lists
   int h0 [7] = '{5, -3, 18, -128, 18, -3, 5};
   int h1 [6] = '{127, -128, 9, -9, 128, -127};
   longint hist0 [7];
   longint hist1 [6];

   int n_chk = 0;
   int n_fail = 0;
   bit     exp_v = 1'b0;
   longint exp0 = 0, exp1 = 0, last0 = 0, last1 = 0;
   string  tag = "R3";

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic clear_ref();
      for (int k = 0; k < 7; k++) hist0[k] = 0;
      for (int k = 0; k < 6; k++) hist1[k] = 0;
      exp_v = 1'b0; last0 = 0; last1 = 0;
   endtask

   // compare outputs produced by the previous step
   task automatic check_prev();
      check(out_valid0 == exp_v, "R2", longint'(out_valid0), longint'(exp_v));
      check(out_valid1 == exp_v, "R2", longint'(out_valid1), longint'(exp_v));
      if (exp_v) begin
         check(longint'(out_data0) == exp0, tag, longint'(out_data0), exp0);
         check(longint'(out_data1) == exp1, tag, longint'(out_data1), exp1);
         last0 = exp0; last1 = exp1;
      end else begin
         check(longint'(out_data0) == last0, "R6", longint'(out_data0), last0);
         check(longint'(out_data1) == last1, "R6", longint'(out_data1), last1);
      end
   endtask

   task automatic step(input bit v, input int x);
      @(negedge clk);
      check_prev();
      in_valid = v;
      in_data  = W'(x);
      if (v) begin
         for (int k = 6; k > 0; k--) hist0[k] = hist0[k-1];
         for (int k = 5; k > 0; k--) hist1[k] = hist1[k-1];
         hist0[0] = longint'(x);
         hist1[0] = longint'(x);
         exp0 = 0; exp1 = 0;
         for (int k = 0; k < 7; k++) exp0 += longint'(h0[k]) * hist0[k];
         for (int k = 0; k < 6; k++) exp1 += longint'(h1[k]) * hist1[k];
      end
      exp_v = v;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      // R1: cleared while in reset
      check(out_valid0 == 1'b0 && out_data0 == '0, "R1", longint'(out_data0), 0);
      check(out_valid1 == 1'b0 && out_data1 == '0, "R1", longint'(out_data1), 0);
      rst_n = 1'b1;
      clear_ref();
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
      report();
   end

   initial begin
      clear_ref();
      repeat (3) @(negedge clk);
      do_reset();
      // R1: first output after reset is h(0)*x only
      tag = "R1";
      step(1'b1, 7);
      tag = "R3";
      // R3/R4/R5: exhaustive back-to-back sweep of every sample value
      for (int x = -128; x < 128; x++) step(1'b1, x);
      // R6: gaps in the valid strobe do not advance the chain
      for (int i = 0; i < 40; i++) step((i % 3) == 0, (i * 37) % 256 - 128);
      // R4: impulse shows single centre tap in odd-length filter
      tag = "R4";
      step(1'b1, 1);
      for (int i = 0; i < 7; i++) step(1'b1, 0);
      // R5: impulse of -1 exercises negated mirror taps
      tag = "R5";
      step(1'b1, -1);
      for (int i = 0; i < 6; i++) step(1'b1, 0);
      // R7: extreme runs
      tag = "R7";
      for (int i = 0; i < 10; i++) step(1'b1, -128);
      for (int i = 0; i < 10; i++) step(1'b1, 127);
      for (int i = 0; i < 14; i++) step(1'b1, (i % 2) ? 127 : -128);
      for (int i = 0; i < 14; i++) step(1'b1, (i % 2) ? -128 : 127);
      // R1: reset in the middle of a stream
      step(1'b0, 0);
      do_reset();
      tag = "R1";
      step(1'b1, -128);
      tag = "R3";
      step(1'b1, 55);
      for (int x = 0; x < 60; x++) step(1'b1, (x * 91) % 256 - 128);
      step(1'b0, 0);
      step(1'b0, 0);
      report();
   end
endmodule